// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a byte-wide bank of housekeeping registers on a simple memory-mapped bus. A host writes and reads a configuration byte, two auxiliary bytes, a diagnostic byte, a modem-control byte and a system-control byte. A separate power-management location is also decoded. Some writes have side effects. They raise one-clock request pulses for shutdown, system reset or CPU halt, which other logic in the chip acts on.

A board-level power-fail input passes through a synchronizer. It is sampled every clock into a power-fail flag that software sees in the second auxiliary register. When enabled in the configuration byte, the flag drives a level interrupt. Software acknowledges the flag by writing the second auxiliary register.

There are two reset paths. The asynchronous power-on reset clears everything. A synchronous soft reset clears only configuration, auxiliary and modem control, and leaves the diagnostic and system-control bytes as they were. The bus is a plain strobe interface with no back-pressure: every write takes effect in its cycle, and every read returns data one cycle later.

Top module: `aux_sysctl_top`

## Requirements
- R1: A register is selected by ANDing the bus address with 0x0FFF0000 and comparing the result to its window. The windows are configuration 0x1800000 (bit 3 is the power-fail enable), auxiliary-1 0x1900000, auxiliary-2 0x1910000, diagnostic 0x1A00000, modem 0x1B00000, system control 0x1F00000 and power management 0xA000000. An address that matches no window reads 0, and a write to it changes nothing.
- R2: Configuration, auxiliary-1, diagnostic and modem control store the whole written byte and return it unchanged on a read.
- R3: Read data is registered. `rd_data` shows the selected value in the clock after `rd_en` is sampled, and it is 0 after any cycle without `rd_en`. A read in the same cycle as a write returns the old value.
- R4: `pwr_fail_in` passes through two flip-flops. On every clock, the flag (auxiliary-2 bit 2) is loaded with the synchronized input AND the configuration bit 3 as it was before that clock.
- R5: `irq_out` is high exactly when the flag and configuration bit 3 are both set.
- R6: A write to auxiliary-2 stores data bit 0 as bit 0. If data bit 1 is set, the flag is cleared in that cycle. Bit 1 and bits 7:3 always read 0.
- R7: A write to auxiliary-2 with data bit 0 set gives a one-clock `shutdown_req` in the next cycle.
- R8: A write to system control with data bit 0 set loads the register with 0x02 and gives a one-clock `reset_req` in the next cycle. With data bit 0 clear, the write has no effect.
- R9: Any write to the power-management window gives a one-clock `halt_req` in the next cycle. Reads of that window return 0.
- R10: While `rst_n` is low, every register, the flag, `rd_data` and all request outputs are 0.
- R11: A clock with `soft_rst` high clears configuration, auxiliary-1, auxiliary-2 (with the flag) and modem control, and keeps diagnostic and system control. A write in that same cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| soft_rst | input | 1 | Synchronous partial reset, active high |
| bus_addr | input | 32 | Byte address |
| wr_data | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| pwr_fail_in | input | 1 | Asynchronous power-fail level |
| irq_out | output | 1 | Power-fail interrupt level |
| shutdown_req | output | 1 | One-clock shutdown request |
| reset_req | output | 1 | One-clock system reset request |
| halt_req | output | 1 | One-clock CPU halt request |

## Verification
The bench applies several kinds of stimulus, each aimed at a different fault:
- Plain byte patterns such as 0xA5 and 0x5A written to every storage register, which expose swapped windows and stuck bits.
- Addresses with junk in the bits outside the decode mask, which show whether decoding is coarse.
- Near-miss addresses, which show whether decoding is exact.
- A power-fail level held across writes to the enable bit and the acknowledge bit, which tests when the flag and interrupt follow the input and when they are cleared.
- System-control writes with bit 0 clear and then set, which separate a pure store from the side-effect rule.
- A soft reset followed by a power-on reset, which shows which bytes each reset keeps.

A behavioural model of every output is compared on every clock, so a pulse that arrives a cycle late, or a read that returns the written value too early, is caught.

// File: rtl/aux_sysctl_pkg.sv
package aux_sysctl_pkg;
  localparam int ADDR_W = 32;
  localparam logic [ADDR_W-1:0] DEC_MASK = 32'h0FFF_0000;

  typedef enum logic [2:0] {
    WIN_CFG   = 3'd0,
    WIN_AUX1  = 3'd1,
    WIN_AUX2  = 3'd2,
    WIN_DIAG  = 3'd3,
    WIN_MODEM = 3'd4,
    WIN_SYS   = 3'd5,
    WIN_PM    = 3'd6
  } win_e;

  localparam int N_WIN = 7;

  // bit positions with behaviour tied to them
  localparam int PF_EN_BIT  = 3;  // configuration: power-fail enable
  localparam int PF_FLG_BIT = 2;  // auxiliary-2: power-fail flag
  localparam int ACK_BIT    = 1;  // auxiliary-2 write: clear flag
  localparam int CMD_BIT    = 0;  // aux-2 shutdown / sysctl reset command

  function automatic logic [ADDR_W-1:0] win_base(input int idx);
    case (idx)
      0:       return 32'h0180_0000;
      1:       return 32'h0190_0000;
      2:       return 32'h0191_0000;
      3:       return 32'h01A0_0000;
      4:       return 32'h01B0_0000;
      5:       return 32'h01F0_0000;
      default: return 32'h0A00_0000;
    endcase
  endfunction
endpackage

// File: rtl/aux_addr_dec.sv
module aux_addr_dec
  import aux_sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output logic [N_WIN-1:0]  hit
);
  logic [ADDR_W-1:0] masked;
  assign masked = addr & DEC_MASK;

  for (genvar i = 0; i < N_WIN; i++) begin : g_win
    assign hit[i] = (masked == win_base(i));
  end
endmodule

// File: rtl/aux_sync.sv
module aux_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[i] <= 1'b0;
      else        chain[i] <= chain[i-1];
    end
  end

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/aux_reg_bank.sv
module aux_reg_bank
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [N_WIN-1:0]  hit,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              pf_sync,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_out,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              halt_req
);
  localparam logic [DATA_W-1:0] SYS_DONE = DATA_W'(2);

  logic [DATA_W-1:0] cfg_q, aux1_q, diag_q, modem_q, sys_q;
  logic              cmd0_q, flag_q;
  logic [DATA_W-1:0] aux2_view, rd_mux;
  logic              wr_ok;

  assign wr_ok = wr_en & ~soft_rst;

  always_comb begin
    aux2_view = '0;
    aux2_view[CMD_BIT]    = cmd0_q;
    aux2_view[PF_FLG_BIT] = flag_q;
  end

  always_comb begin
    rd_mux = '0;
    unique case (1'b1)
      hit[WIN_CFG]:   rd_mux = cfg_q;
      hit[WIN_AUX1]:  rd_mux = aux1_q;
      hit[WIN_AUX2]:  rd_mux = aux2_view;
      hit[WIN_DIAG]:  rd_mux = diag_q;
      hit[WIN_MODEM]: rd_mux = modem_q;
      hit[WIN_SYS]:   rd_mux = sys_q;
      default:        rd_mux = '0;
    endcase
  end

  // registers cleared by either reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      modem_q <= '0;
      cmd0_q <= 1'b0;
      flag_q <= 1'b0;
    end else if (soft_rst) begin
      cfg_q  <= '0;
      aux1_q <= '0;
      modem_q <= '0;
      cmd0_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= pf_sync & cfg_q[PF_EN_BIT];
      if (wr_en && hit[WIN_CFG])   cfg_q   <= wr_data;
      if (wr_en && hit[WIN_AUX1])  aux1_q  <= wr_data;
      if (wr_en && hit[WIN_MODEM]) modem_q <= wr_data;
      if (wr_en && hit[WIN_AUX2]) begin
        cmd0_q <= wr_data[CMD_BIT];
        if (wr_data[ACK_BIT]) flag_q <= 1'b0;
      end
    end
  end

  // registers kept through soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_q <= '0;
      sys_q  <= '0;
    end else if (wr_ok) begin
      if (hit[WIN_DIAG]) diag_q <= wr_data;
      if (hit[WIN_SYS] && wr_data[CMD_BIT]) sys_q <= SYS_DONE;
    end
  end

  // request pulses and read data
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
      halt_req     <= 1'b0;
      rd_data      <= '0;
    end else begin
      shutdown_req <= wr_ok & hit[WIN_AUX2] & wr_data[CMD_BIT];
      reset_req    <= wr_ok & hit[WIN_SYS]  & wr_data[CMD_BIT];
      halt_req     <= wr_ok & hit[WIN_PM];
      rd_data      <= rd_en ? rd_mux : '0;
    end
  end

  assign irq_out = flag_q & cfg_q[PF_EN_BIT];

  assert_flag_from_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(pf_sync));
  assert_shutdown_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(wr_en && !soft_rst && hit[WIN_AUX2] && wr_data[CMD_BIT]));
  assert_reset_loads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> (sys_q == SYS_DONE));
  assert_halt_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req |-> $past(wr_en && !soft_rst && hit[WIN_PM]));
  assert_soft_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ($stable(diag_q) && $stable(sys_q) && cfg_q == '0 && !irq_out));
endmodule

// File: rtl/aux_sysctl_top.sv
module aux_sysctl_top
  import aux_sysctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              pwr_fail_in,
  output logic              irq_out,
  output logic              shutdown_req,
  output logic              reset_req,
  output logic              halt_req
);
  logic [N_WIN-1:0] hit;
  logic             pf_sync;

  aux_addr_dec u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  aux_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (pwr_fail_in),
    .d_out (pf_sync)
  );

  aux_reg_bank #(.DATA_W(DATA_W)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .hit          (hit),
    .wr_data      (wr_data),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .pf_sync      (pf_sync),
    .rd_data      (rd_data),
    .irq_out      (irq_out),
    .shutdown_req (shutdown_req),
    .reset_req    (reset_req),
    .halt_req     (halt_req)
  );

  assert_pulses_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({shutdown_req, reset_req, halt_req}) <= 1);
endmodule

// File: tb/tb_aux_sysctl_top.sv
module tb_aux_sysctl_top;
  localparam int CLK_P = 10;

  localparam logic [31:0] A_CFG = 32'h0180_0000, A_AUX1 = 32'h0190_0000,
    A_AUX2 = 32'h0191_0000, A_DIAG = 32'h01A0_0000, A_MODEM = 32'h01B0_0000,
    A_SYS = 32'h01F0_0000, A_PM = 32'h0A00_0000;

  logic clk = 0, rst_n = 0, soft_rst = 0, wr_en = 0, rd_en = 0, pwr_fail_in = 0;
  logic [31:0] bus_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic irq_out, shutdown_req, reset_req, halt_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  aux_sysctl_top dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .wr_data(wr_data), .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
    .pwr_fail_in(pwr_fail_in), .irq_out(irq_out), .shutdown_req(shutdown_req),
    .reset_req(reset_req), .halt_req(halt_req)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_cfg, m_aux1, m_diag, m_modem, m_sys, m_rd;
  logic m_b0, m_flag, m_sd, m_rr, m_hl, m_p1, m_p2;

  function automatic logic [7:0] m_read(input logic [31:0] a);
    logic [31:0] k;
    k = a & 32'h0FFF_0000;
    if (k == A_CFG)   return m_cfg;
    if (k == A_AUX1)  return m_aux1;
    if (k == A_AUX2)  return {5'b0, m_flag, 1'b0, m_b0};
    if (k == A_DIAG)  return m_diag;
    if (k == A_MODEM) return m_modem;
    if (k == A_SYS)   return m_sys;
    return 8'h00;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg = 0; m_aux1 = 0; m_diag = 0; m_modem = 0; m_sys = 0; m_rd = 0;
      m_b0 = 0; m_flag = 0; m_sd = 0; m_rr = 0; m_hl = 0; m_p1 = 0; m_p2 = 0;
    end else begin
      logic [31:0] k;
      logic [7:0]  cfg_old;
      logic        p2_old;
      k = bus_addr & 32'h0FFF_0000;
      cfg_old = m_cfg;
      p2_old = m_p2;
      m_rd = rd_en ? m_read(bus_addr) : 8'h00;
      m_p2 = m_p1; m_p1 = pwr_fail_in;
      m_sd = 0; m_rr = 0; m_hl = 0;
      if (soft_rst) begin
        m_cfg = 0; m_aux1 = 0; m_modem = 0; m_b0 = 0; m_flag = 0;
      end else begin
        m_flag = p2_old & cfg_old[3];
        if (wr_en) begin
          if (k == A_CFG)   m_cfg = wr_data;
          if (k == A_AUX1)  m_aux1 = wr_data;
          if (k == A_DIAG)  m_diag = wr_data;
          if (k == A_MODEM) m_modem = wr_data;
          if (k == A_AUX2) begin
            m_b0 = wr_data[0];
            if (wr_data[1]) m_flag = 0;
            m_sd = wr_data[0];
          end
          if (k == A_SYS && wr_data[0]) begin m_sys = 8'h02; m_rr = 1; end
          if (k == A_PM) m_hl = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3", "rd_data", rd_data, m_rd);
      chk("R5", "irq_out", {7'b0, irq_out}, {7'b0, m_flag & m_cfg[3]});
      chk("R7", "shutdown_req", {7'b0, shutdown_req}, {7'b0, m_sd});
      chk("R8", "reset_req", {7'b0, reset_req}, {7'b0, m_rr});
      chk("R9", "halt_req", {7'b0, halt_req}, {7'b0, m_hl});
    end
  end

  // ---------------- stimulus tasks (called at a negedge) ----------------
  task automatic wr(input logic [31:0] a, input logic [7:0] d);
    bus_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string req, input logic [31:0] a, input logic [7:0] exp);
    bus_addr = a; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(req, "read", rd_data, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    idle(3);
    // R10: reset state
    chk("R10", "rd_data in reset", rd_data, 8'h00);
    chk("R10", "pulses in reset", {5'b0, shutdown_req, reset_req, halt_req}, 8'h00);
    rst_n = 1;
    idle(1);
    rd("R10", A_DIAG, 8'h00);
    rd("R10", A_SYS, 8'h00);

    // R2: byte storage
    wr(A_CFG, 8'hA5);  wr(A_AUX1, 8'h3C);
    wr(A_DIAG, 8'h5A); wr(A_MODEM, 8'hC3);
    rd("R2", A_CFG, 8'hA5);  rd("R2", A_AUX1, 8'h3C);
    rd("R2", A_DIAG, 8'h5A); rd("R2", A_MODEM, 8'hC3);

    // R1: coarse decode, aliases and near misses
    wr(A_AUX1 | 32'hF000_1234, 8'h77);
    rd("R1", A_AUX1 | 32'h0000_FFFF, 8'h77);
    wr(32'h01C0_0000, 8'hFF);
    rd("R1", 32'h01C0_0000, 8'h00);
    rd("R1", 32'h0192_0000, 8'h00);
    rd("R2", A_MODEM, 8'hC3);

    // R3: idle cycle gives zero
    idle(1);
    chk("R3", "idle rd_data", rd_data, 8'h00);

    // R4/R5: power-fail flag and interrupt
    wr(A_CFG, 8'h08);
    pwr_fail_in = 1;
    idle(4);
    chk("R5", "irq high", {7'b0, irq_out}, 8'h01);
    rd("R4", A_AUX2, 8'h04);
    wr(A_CFG, 8'h00);
    idle(1);
    chk("R5", "irq off when disabled", {7'b0, irq_out}, 8'h00);
    rd("R4", A_AUX2, 8'h00);
    wr(A_CFG, 8'h08);
    idle(2);
    // R6: acknowledge clears flag for a cycle while input still high
    wr(A_AUX2, 8'h02);
    chk("R6", "irq after ack", {7'b0, irq_out}, 8'h00);
    idle(1);
    pwr_fail_in = 0;
    idle(4);
    rd("R4", A_AUX2, 8'h00);

    // R6/R7: shutdown command
    wr(A_AUX2, 8'hFF);
    chk("R7", "shutdown pulse", {7'b0, shutdown_req}, 8'h01);
    rd("R6", A_AUX2, 8'h01);
    chk("R7", "shutdown one clock", {7'b0, shutdown_req}, 8'h00);
    wr(A_AUX2, 8'h00);
    rd("R6", A_AUX2, 8'h00);

    // R8: system control
    wr(A_SYS, 8'hFE);
    rd("R8", A_SYS, 8'h00);
    wr(A_SYS, 8'h01);
    chk("R8", "reset pulse", {7'b0, reset_req}, 8'h01);
    rd("R8", A_SYS, 8'h02);
    wr(A_SYS, 8'h00);
    rd("R8", A_SYS, 8'h02);

    // R9: power management
    wr(A_PM, 8'h00);
    chk("R9", "halt pulse", {7'b0, halt_req}, 8'h01);
    rd("R9", A_PM, 8'h00);

    // R11: soft reset (with a write in the same cycle)
    wr(A_CFG, 8'h99); wr(A_AUX1, 8'h11); wr(A_MODEM, 8'h22);
    wr(A_AUX2, 8'h01); wr(A_DIAG, 8'h44);
    soft_rst = 1;
    bus_addr = A_DIAG; wr_data = 8'hEE; wr_en = 1;
    @(negedge clk);
    soft_rst = 0; wr_en = 0;
    rd("R11", A_CFG, 8'h00);   rd("R11", A_AUX1, 8'h00);
    rd("R11", A_MODEM, 8'h00); rd("R11", A_AUX2, 8'h00);
    rd("R11", A_DIAG, 8'h44);  rd("R11", A_SYS, 8'h02);

    // R10: power-on reset clears the kept bytes too
    rst_n = 0;
    idle(2);
    rst_n = 1;
    idle(1);
    rd("R10", A_DIAG, 8'h00);
    rd("R10", A_SYS, 8'h00);
    idle(2);
    summary();
  end
endmodule